// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates thirteen interrupt sources for a small 8-bit processor core and hands the core one request line plus the 8-bit entry address of the winning handler. Each source can be enabled on its own and placed in a high or a low priority class. Inside a class, a fixed natural order decides between simultaneous requests. A global enable masks every source at once.

The controller keeps one in-service bit per priority class. A high-class request can interrupt a low-class handler. A low-class request waits until no handler is running. The core accepts a request by pulsing `boundary_i` at an instruction boundary while `irq_o` is high. It reports the end of a handler by pulsing `reti_i`.

Six external pins pass through a two-flop synchronizer. Each pin has its own polarity and can work in edge mode or level mode. Edge-mode flags are latched and then cleared by hardware when their vector is taken. Software reaches the enables, priorities, pin modes, edge flags and a status byte through a small register port with eight addresses.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every register reads 0, the status register (address 6) reads 8'h1F, and `irq_o` is 0.
- R2: While the global enable (address 0 bit 7) is 0, `irq_o` stays 0 whatever the requests are.
- R3: Inside one priority class, the candidate is the enabled pending source that comes first in this order: power-fail, ext0, timer0, ext1, timer1, serial0, timer2, serial1, ext2, ext3, ext4, ext5, watchdog.
- R4: `vec_o` gives the entry address of the candidate:
  - ext0 03h, timer0 0Bh, ext1 13h, timer1 1Bh, serial0 23h, timer2 2Bh;
  - power-fail 33h, serial1 3Bh;
  - ext2 43h, ext3 4Bh, ext4 53h, ext5 5Bh, watchdog 63h.
- R5: A high-class request is offered only while no high handler is in service. A low-class request is offered only while no handler of either class is in service.
- R6: `boundary_i` while `irq_o` is 1 takes the vector and sets the in-service bit of its class. Status bit 7 shows high in service, bit 6 shows low in service, and bits 4:0 read 1.
- R7: `reti_i` clears the high in-service bit if it is set, otherwise the low one.
- R8: The pins for ext0, ext1, ext3 and ext5 are active low. The pins for ext2 and ext4 are active high.
- R9: When a pin's bit in the mode register (address 5, bit n = ext n) is 1, the pin works in edge mode: the active edge, seen after the synchronizer, sets a flag that holds until its vector is taken. When the bit is 0, the request follows the pin level. Address 4 shows the requests of ext0 and ext1 in bits 0 and 1 and of ext2 to ext5 in bits 4 to 7.
- R10: If `boundary_i` and `reti_i` come in the same cycle, the return clears a class according to the in-service state before that edge, and the class of the taken vector is then set.
- R11: Addresses 0 and 2 (enable and priority) use bits 0 to 6 for ext0, timer0, ext1, timer1, serial0, timer2, serial1, and address 0 bit 7 is the global enable. Addresses 1 and 3 use bits 0 to 3 for ext2 to ext5, bit 4 for the watchdog and bit 5 for power-fail. A priority bit of 1 means the high class.
- R12: Status bit 5 is set when the power-fail vector is taken. It clears when the return strobe clears the class that the power-fail vector was taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfail_i | input | 1 | Power-fail warning request |
| tmr_i | input | 3 | Timer 0..2 overflow requests |
| ser_i | input | 2 | Serial 0..1 requests |
| wdog_i | input | 1 | Watchdog early-warning request |
| ext_pin_i | input | 6 | External interrupt pins ext0..ext5 |
| boundary_i | input | 1 | Instruction boundary; accepts the offered vector |
| reti_i | input | 1 | Return-from-handler strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 8 | Entry address of the offered source |

## Verification
A vector can be accepted in the same cycle that a handler returns. Both strobes then change the two in-service bits on one edge. The bench puts a low handler in service, raises a high-class timer request, and pulses `boundary_i` and `reti_i` together. It then reads the status byte and expects high in service and low clear. A second pair of events can also meet: a pin edge and the hardware clear of its flag. For that case the bench checks that the edge flag survives after the pin falls back, and that only the take clears it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 13;
  localparam int IDXW = $clog2(NSRC);
  localparam int NEXT = 6;
  localparam logic [NEXT-1:0] EXT_ACT_LOW = 6'b101011;
  localparam logic [7:0] PF_VEC = 8'h33;

  // natural index -> entry address (index 0 is power-fail)
  function automatic logic [7:0] nat_vec(input logic [IDXW-1:0] idx);
    if (idx == '0)        return PF_VEC;
    else if (idx <= 4'd6) return 8'h03 + 8'(idx - 1) * 8'd8;
    else                  return 8'h03 + 8'(idx) * 8'd8;
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 13,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end

  // R3
  always_comb begin
    if (found_o) begin
      lowest_wins_chk: assert ((req_i & ((N'(1) << idx_o) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/irq_ext_detect.sv
module irq_ext_detect #(
  parameter int N = 6,
  parameter logic [N-1:0] ACT_LOW = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, s3_q, flag_q, act, act_prev, rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= ACT_LOW[g];
        s2_q <= ACT_LOW[g];
        s3_q <= ACT_LOW[g];
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign act      = s2_q ^ ACT_LOW[g];
    assign act_prev = s3_q ^ ACT_LOW[g];
    assign rise     = edge_mode_i[g] & act & ~act_prev;

    // a fresh edge wins over both software write and hardware clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= 1'b0;
      else if (rise)    flag_q <= 1'b1;
      else if (wr_i)    flag_q <= wdata_i[g];
      else if (clr_i[g]) flag_q <= 1'b0;
    end

    assign req_o[g] = edge_mode_i[g] ? flag_q : act;

    // R9
    edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise |=> flag_q);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pfail_i,
  input  logic [2:0] tmr_i,
  input  logic [1:0] ser_i,
  input  logic       wdog_i,
  input  logic [5:0] ext_pin_i,
  input  logic       boundary_i,
  input  logic       reti_i,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  output logic [7:0] vec_o
);
  localparam int ALO_W = 7;
  localparam int AHI_W = 6;

  logic [ALO_W:0]   en_a_q;
  logic [AHI_W-1:0] en_b_q, pri_b_q;
  logic [ALO_W-1:0] pri_a_q;
  logic [NEXT-1:0]  mode_q, ext_req, ext_clr;
  logic             hi_q, lo_q, pf_q, pf_hi_q;
  logic [NSRC-1:0]  req_nat, en_nat, pri_nat, pend;
  logic             hi_found, lo_found, sel_hi, take, ret_hi, ret_lo;
  logic [IDXW-1:0]  hi_idx, lo_idx, win_idx;
  logic             flag_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_a_q <= '0; en_b_q <= '0; pri_a_q <= '0; pri_b_q <= '0; mode_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        3'd0: en_a_q  <= reg_wdata_i;
        3'd1: en_b_q  <= reg_wdata_i[AHI_W-1:0];
        3'd2: pri_a_q <= reg_wdata_i[ALO_W-1:0];
        3'd3: pri_b_q <= reg_wdata_i[AHI_W-1:0];
        3'd5: mode_q  <= reg_wdata_i[NEXT-1:0];
        default: ;
      endcase
    end
  end

  assign flag_wr = reg_we_i && reg_addr_i == 3'd4;

  irq_ext_detect #(.N(NEXT), .ACT_LOW(EXT_ACT_LOW)) u_ext (
    .clk_i, .rst_ni,
    .pin_i(ext_pin_i), .edge_mode_i(mode_q), .clr_i(ext_clr),
    .wr_i(flag_wr), .wdata_i({reg_wdata_i[7:4], reg_wdata_i[1:0]}),
    .req_o(ext_req)
  );

  assign req_nat = {wdog_i, ext_req[5:2], ser_i[1], tmr_i[2], ser_i[0],
                    tmr_i[1], ext_req[1], tmr_i[0], ext_req[0], pfail_i};
  assign en_nat  = {en_b_q[4], en_b_q[3:0], en_a_q[ALO_W-1:0], en_b_q[5]};
  assign pri_nat = {pri_b_q[4], pri_b_q[3:0], pri_a_q, pri_b_q[5]};
  assign pend    = req_nat & en_nat & {NSRC{en_a_q[ALO_W]}};

  irq_prio_pick #(.N(NSRC), .W(IDXW)) u_pick_hi (
    .req_i(pend & pri_nat), .found_o(hi_found), .idx_o(hi_idx));
  irq_prio_pick #(.N(NSRC), .W(IDXW)) u_pick_lo (
    .req_i(pend & ~pri_nat), .found_o(lo_found), .idx_o(lo_idx));

  assign sel_hi  = hi_found & ~hi_q;
  assign irq_o   = sel_hi | (lo_found & ~hi_q & ~lo_q);
  assign win_idx = sel_hi ? hi_idx : lo_idx;
  assign vec_o   = irq_o ? nat_vec(win_idx) : 8'h00;
  assign take    = boundary_i & irq_o;
  assign ret_hi  = reti_i & hi_q;
  assign ret_lo  = reti_i & ~hi_q & lo_q;

  always_comb begin
    ext_clr    = '0;
    ext_clr[0] = take && win_idx == IDXW'(1);
    ext_clr[1] = take && win_idx == IDXW'(3);
    for (int k = 2; k < NEXT; k++) ext_clr[k] = take && win_idx == IDXW'(k + 6);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0; lo_q <= 1'b0; pf_q <= 1'b0; pf_hi_q <= 1'b0;
    end else begin
      hi_q <= (hi_q & ~ret_hi) | (take & sel_hi);
      lo_q <= (lo_q & ~ret_lo) | (take & ~sel_hi);
      if (take && win_idx == '0) begin
        pf_q    <= 1'b1;
        pf_hi_q <= sel_hi;
      end else if ((ret_hi && pf_hi_q) || (ret_lo && !pf_hi_q)) begin
        pf_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      3'd0: reg_rdata_o = en_a_q;
      3'd1: reg_rdata_o = {2'b00, en_b_q};
      3'd2: reg_rdata_o = {1'b0, pri_a_q};
      3'd3: reg_rdata_o = {2'b00, pri_b_q};
      3'd4: reg_rdata_o = {ext_req[5:2], 2'b00, ext_req[1:0]};
      3'd5: reg_rdata_o = {2'b00, mode_q};
      3'd6: reg_rdata_o = {hi_q, lo_q, pf_q, 5'b11111};
      default: reg_rdata_o = 8'h00;
    endcase
  end

  // R2
  gie_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_a_q[ALO_W] |-> !irq_o);
  // R5
  no_preempt_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q |-> !irq_o);
  // R6
  take_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (hi_q || lo_q));
  // R7
  ret_hi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take && hi_q && lo_q) |=> (!hi_q && lo_q));
  // R12
  pf_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_q |-> (hi_q || lo_q));
  // R4
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vec_o[2:0] == 3'b011);
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pfail = 1'b0, wdog = 1'b0, boundary = 1'b0, reti = 1'b0;
  logic [2:0] tmr = '0;
  logic [1:0] ser = '0;
  logic [5:0] pins = 6'b101011;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, vec;
  logic       irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pfail_i(pfail), .tmr_i(tmr), .ser_i(ser),
    .wdog_i(wdog), .ext_pin_i(pins), .boundary_i(boundary), .reti_i(reti),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic strobe(input logic b, input logic r);
    @(negedge clk); boundary = b; reti = r;
    @(negedge clk); boundary = 1'b0; reti = 1'b0;
  endtask

  // expected entry address by natural position (R4)
  function automatic logic [7:0] exp_vec(input int i);
    case (i)
      0: return 8'h33;  1: return 8'h03;  2: return 8'h0B;  3: return 8'h13;
      4: return 8'h1B;  5: return 8'h23;  6: return 8'h2B;  7: return 8'h3B;
      8: return 8'h43;  9: return 8'h4B; 10: return 8'h53; 11: return 8'h5B;
      default: return 8'h63;
    endcase
  endfunction

  // nothing in service: returns {found, vector}
  function automatic logic [8:0] model(input logic [12:0] r, input logic [7:0] ea,
      input logic [5:0] eb, input logic [6:0] pa, input logic [5:0] pb);
    logic [12:0] en, pr, p;
    en = {eb[4], eb[3:0], ea[6:0], eb[5]};
    pr = {pb[4], pb[3:0], pa, pb[5]};
    p  = r & en & {13{ea[7]}};
    for (int i = 0; i < 13; i++) if (p[i] & pr[i]) return {1'b1, exp_vec(i)};
    for (int i = 0; i < 13; i++) if (p[i] & ~pr[i]) return {1'b1, exp_vec(i)};
    return 9'h0;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 irq", irq, 0);
    rd(3'd6, d); chk("R1 status", d, 8'h1F);
    rd(3'd0, d); chk("R1 en_a", d, 0);
    rd(3'd3, d); chk("R1 pri_b", d, 0);

    // R2: power-fail enabled but global enable clear
    wr(3'd1, 8'h20); pfail = 1'b1; settle();
    chk("R2 masked", irq, 0);
    wr(3'd0, 8'h80); settle();
    chk("R2 unmasked", irq, 1); chk("R4 pf vec", vec, 8'h33);
    pfail = 1'b0;

    // R3/R4 ordering among low class
    wr(3'd0, 8'hFF); wr(3'd1, 8'h1F);
    tmr = 3'b001; ser = 2'b10; settle();
    chk("R3 t0 over s1", vec, 8'h0B);
    tmr = 0; settle(); chk("R4 s1 vec", vec, 8'h3B);
    ser = 0; wdog = 1'b1; settle(); chk("R4 wd vec", vec, 8'h63);
    // R11: watchdog high-class beats serial1
    ser = 2'b10; wr(3'd3, 8'h10); settle();
    chk("R11 wd high", vec, 8'h63);
    wr(3'd3, 8'h00); settle(); chk("R11 s1 low", vec, 8'h3B);
    rd(3'd1, d); chk("R11 en_b readback", d, 8'h1F);
    wdog = 0; ser = 0;

    // R5/R6/R7/R12 nesting
    wr(3'd0, 8'h88); wr(3'd1, 8'h20); wr(3'd3, 8'h20);
    tmr = 3'b010; settle(); chk("R4 t1 vec", vec, 8'h1B);
    strobe(1, 0); rd(3'd6, d); chk("R6 low in service", d, 8'h5F);
    wr(3'd0, 8'h98); ser = 2'b01; settle();
    chk("R5 low no preempt", irq, 0);
    pfail = 1'b1; settle(); chk("R5 high preempts", irq, 1);
    chk("R4 pf vec2", vec, 8'h33);
    strobe(1, 0); rd(3'd6, d); chk("R12 high+pf", d, 8'hFF);
    chk("R5 hi blocks", irq, 0);
    pfail = 0; ser = 0; tmr = 0;
    strobe(0, 1); rd(3'd6, d); chk("R7 hi cleared first", d, 8'h5F);
    strobe(0, 1); rd(3'd6, d); chk("R7 lo cleared", d, 8'h1F);
    wr(3'd3, 8'h00); pfail = 1'b1; settle();
    strobe(1, 0); rd(3'd6, d); chk("R12 low pf", d, 8'h7F);
    pfail = 0; strobe(0, 1); rd(3'd6, d); chk("R12 pf cleared", d, 8'h1F);

    // R10 take and return in one cycle
    wr(3'd0, 8'h8A); wr(3'd2, 8'h02); tmr = 3'b010; settle();
    strobe(1, 0); rd(3'd6, d); chk("R10 setup", d, 8'h5F);
    tmr = 3'b011; settle(); chk("R10 offer", vec, 8'h0B);
    strobe(1, 1); rd(3'd6, d); chk("R10 same cycle", d, 8'h9F);
    tmr = 0; strobe(0, 1); rd(3'd6, d); chk("R10 end", d, 8'h1F);
    wr(3'd2, 8'h00);

    // R8/R9 external pins, edge mode on ext2/ext3
    wr(3'd0, 8'h80); wr(3'd1, 8'h0F); wr(3'd5, 8'h0C);
    pins[2] = 1'b1; settle();
    rd(3'd4, d); chk("R9 ext2 flag", d, 8'h10); chk("R4 ext2 vec", vec, 8'h43);
    pins[2] = 1'b0; settle(); chk("R9 flag held", irq, 1);
    strobe(1, 0); rd(3'd4, d); chk("R9 cleared on take", d, 8'h00);
    strobe(0, 1);
    pins[3] = 1'b0; settle();
    rd(3'd4, d); chk("R8 ext3 active low edge", d, 8'h20);
    chk("R4 ext3 vec", vec, 8'h4B);
    pins[3] = 1'b1; strobe(1, 0); strobe(0, 1);
    wr(3'd5, 8'h00);
    pins[5] = 1'b0; settle(); chk("R8 ext5 level", vec, 8'h5B);
    pins[5] = 1'b1; settle(); chk("R9 level follows", irq, 0);
    wr(3'd0, 8'h81); pins[0] = 1'b0; settle(); chk("R8 ext0 low", vec, 8'h03);
    pins[4] = 1'b1; settle(); chk("R3 ext0 over ext4", vec, 8'h03);
    pins[0] = 1'b1; settle(); chk("R8 ext4 high", vec, 8'h53);
    pins[4] = 1'b0; settle(); chk("R9 level off", irq, 0);

    // random level-mode patterns against the model
    for (int it = 0; it < 150; it++) begin
      logic [7:0] ea; logic [5:0] eb, pb; logic [6:0] pa; logic [8:0] m;
      logic [12:0] r; logic [5:0] act;
      ea = 8'($urandom); if (it % 8 != 0) ea[7] = 1'b1;
      eb = 6'($urandom); pa = 7'($urandom); pb = 6'($urandom);
      wr(3'd0, ea); wr(3'd1, {2'b00, eb}); wr(3'd2, {1'b0, pa}); wr(3'd3, {2'b00, pb});
      pfail = 1'($urandom); tmr = 3'($urandom); ser = 2'($urandom);
      wdog = 1'($urandom); pins = 6'($urandom);
      act = pins ^ 6'b101011;
      r = {wdog, act[5:2], ser[1], tmr[2], ser[0], tmr[1], act[1], tmr[0], act[0], pfail};
      settle();
      m = model(r, ea, eb, pa, pb);
      chk("R3 random irq", irq, m[8]);
      if (m[8]) chk("R4 random vec", vec, m[7:0]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule